// File: doc/BRIEF.md
# Programmable Binary Counter with Clocked Carry

A parameterised binary up-counter (four bits by default) that can be cleared or preset in two ways. The first way is immediate and needs no clock edge. The second way takes effect on a rising clock edge. All four of these controls are active low, and they obey a fixed order of precedence. Two count enables gate the increment.

The counter has two carry outputs:
- A combinational ripple carry. It is high at terminal count when the chain enable is high.
- A clocked carry. It can be high only during the low half of the clock, so it is free of the decode glitches that the ripple carry can show.

To form a wider counter, feed the ripple carry of one stage into the chain enable of the next stage. The count outputs can be placed in high impedance without disturbing the count.

Top module: `prog_counter`

## Requirements
- R1: While `clr_async_n` is low, the count is zero immediately, whatever every other input does, including `ld_async_n`.
- R2: While `clr_async_n` is high and `ld_async_n` is low, the count equals `par_d` without any clock edge, and it follows every change on `par_d`. This immediate load beats all three edge-triggered actions.
- R3: With both immediate controls high, a low `clr_sync_n` makes the count zero at the next rising edge. This holds even when `ld_sync_n` is low and both enables are high.
- R4: With `clr_sync_n` high and `ld_sync_n` low, the count takes `par_d` at the next rising edge, whatever the enables are.
- R5: With all four clear/load controls high, the count rises by one at each rising edge, wrapping from all-ones to zero, when `en_local` and `en_chain` are both high. If either enable is low, the count holds.
- R6: `carry_ripple` is high exactly when `en_chain` is high and the count is all ones. It does not depend on `en_local` or on the clock level.
- R7: `carry_clocked` is low during every clock-high phase. During a clock-low phase it equals the value of `carry_ripple & en_local` sampled at the falling edge that began that phase.
- R8: While `out_en_n` is high, `cnt_q` is high impedance on every bit. The internal count keeps counting, and its value appears once `out_en_n` returns low.
- R9: Two stages form a counter of twice the width. To connect them, drive the upper stage's `en_chain` from the lower stage's `carry_ripple` and share the other inputs. The upper stage then advances exactly when the lower stage wraps from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; edge-triggered actions occur on the rising edge |
| clr_async_n | input | 1 | Immediate clear, active low, highest precedence |
| ld_async_n | input | 1 | Immediate load of `par_d`, active low |
| clr_sync_n | input | 1 | Edge-triggered clear, active low |
| ld_sync_n | input | 1 | Edge-triggered load of `par_d`, active low |
| en_local | input | 1 | Count enable for this stage only |
| en_chain | input | 1 | Count enable that also gates the carries |
| par_d | input | WIDTH | Parallel load data |
| out_en_n | input | 1 | Output drive enable, active low |
| cnt_q | output | WIDTH | Count value, high impedance while `out_en_n` is high |
| carry_ripple | output | 1 | Terminal-count carry, combinational |
| carry_clocked | output | 1 | Carry valid only in the clock-low phase |

## Verification
The clocked carry is the hardest output to reach. The bench must hold the full cascade at all ones, keep both enables steady across the falling edge, and then look inside the low half-period before the next rising edge.

To do this, the stimulus drives inputs just after each rising edge. It samples once early in the high phase, where the clocked carry must be low, and once late in the low phase, where it must match the sampled carry term. A hold-at-terminal-count case with only the local enable low separates the two carries: the ripple carry must be high while the clocked carry stays low.

The bench also has to show that the immediate load tracks the data. To do this, it changes `par_d` between cycles while the immediate load is held low, so the count must follow without any edge.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   // Edge-triggered action chosen for the next rising clock edge.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_CLEAR = 2'd1,
      OP_LOAD  = 2'd2,
      OP_INC   = 2'd3
   } sync_op_e;

endpackage

// File: rtl/pcnt_next.sv
module pcnt_next
   import pcnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clr_sync_n,
   input  logic             ld_sync_n,
   input  logic             en_local,
   input  logic             en_chain,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   sync_op_e op;

   // Precedence: the edge-triggered clear beats the load, and the load beats the count.
   always_comb begin
      if (!clr_sync_n)                op = OP_CLEAR;
      else if (!ld_sync_n)            op = OP_LOAD;
      else if (en_local && en_chain)  op = OP_INC;
      else                            op = OP_HOLD;
   end

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = din;
         OP_INC:   nxt = cur + ONE;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/pcnt_bit.sv
module pcnt_bit (
   input  logic clk,
   input  logic arst_n,
   input  logic aset_n,
   input  logic d,
   output logic q
);

   // The asynchronous reset wins over the asynchronous set when both are active.
   always_ff @(posedge clk or negedge arst_n or negedge aset_n) begin
      if (!arst_n)      q <= 1'b0;
      else if (!aset_n) q <= 1'b1;
      else              q <= d;
   end

endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             aclr_n,
   input  logic [WIDTH-1:0] cur,
   input  logic             en_local,
   input  logic             en_chain,
   output logic             ripple,
   output logic             clocked
);

   logic arm;
   logic fall_tg;
   logic rise_tg;

   assign ripple = en_chain && (cur == '1);
   assign arm    = ripple && en_local;

   // Two toggle flops, one per clock edge. The falling edge makes the pair differ
   // when the carry term is set; the rising edge makes them equal again.
   // The XOR of two register outputs never uses the clock as data.
   always_ff @(negedge clk or negedge aclr_n) begin
      if (!aclr_n) fall_tg <= 1'b0;
      else         fall_tg <= rise_tg ^ arm;
   end

   always_ff @(posedge clk or negedge aclr_n) begin
      if (!aclr_n) rise_tg <= 1'b0;
      else         rise_tg <= fall_tg;
   end

   assign clocked = fall_tg ^ rise_tg;

   // R7: the value just before each falling edge belongs to the high phase.
   a_r7_low_in_high_phase: assert property (
      @(negedge clk) disable iff (!aclr_n) clocked == 1'b0
   ) else $error("clocked carry high during clock-high phase");

endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_async_n,
   input  logic             ld_async_n,
   input  logic             clr_sync_n,
   input  logic             ld_sync_n,
   input  logic             en_local,
   input  logic             en_chain,
   input  logic [WIDTH-1:0] par_d,
   input  logic             out_en_n,
   output logic [WIDTH-1:0] cnt_q,
   output logic             carry_ripple,
   output logic             carry_clocked
);

   if (WIDTH < 1) begin : g_bad_width
      $error("prog_counter: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] bit_rst_n;
   logic [WIDTH-1:0] bit_set_n;

   pcnt_next #(.WIDTH(WIDTH)) u_next (
      .clr_sync_n (clr_sync_n),
      .ld_sync_n  (ld_sync_n),
      .en_local   (en_local),
      .en_chain   (en_chain),
      .cur        (q),
      .din        (par_d),
      .nxt        (nxt)
   );

   // The immediate load is built from a per-bit asynchronous set and reset.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_rst_n[i] = clr_async_n && (ld_async_n || par_d[i]);
      assign bit_set_n[i] = !(clr_async_n && !ld_async_n && par_d[i]);

      pcnt_bit u_bit (
         .clk    (clk),
         .arst_n (bit_rst_n[i]),
         .aset_n (bit_set_n[i]),
         .d      (nxt[i]),
         .q      (q[i])
      );
   end

   pcnt_carry #(.WIDTH(WIDTH)) u_carry (
      .clk      (clk),
      .aclr_n   (clr_async_n),
      .cur      (q),
      .en_local (en_local),
      .en_chain (en_chain),
      .ripple   (carry_ripple),
      .clocked  (carry_clocked)
   );

   assign cnt_q = out_en_n ? {WIDTH{1'bz}} : q;

   a_r3_sync_clear: assert property (
      @(posedge clk) disable iff (!clr_async_n || !ld_async_n)
      !clr_sync_n |=> (q == '0)
   ) else $error("edge clear did not zero the count");

   a_r4_sync_load: assert property (
      @(posedge clk) disable iff (!clr_async_n || !ld_async_n)
      (clr_sync_n && !ld_sync_n) |=> (q == $past(par_d))
   ) else $error("edge load did not take the data");

   a_r5_increment: assert property (
      @(posedge clk) disable iff (!clr_async_n || !ld_async_n)
      (clr_sync_n && ld_sync_n && en_local && en_chain) |=> (q == WIDTH'($past(q) + 1))
   ) else $error("count did not advance");

   a_r5_hold: assert property (
      @(posedge clk) disable iff (!clr_async_n || !ld_async_n)
      (clr_sync_n && ld_sync_n && !(en_local && en_chain)) |=> (q == $past(q))
   ) else $error("count moved while an enable was low");

endmodule

// File: tb/prog_counter_tb.sv
module prog_counter_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       ac, al, sc, sl, p, t, oe;
   logic [7:0] d;
   wire  [3:0] q_lo, q_hi;
   logic       rip_lo, rip_hi, cc_lo, cc_hi;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   logic [3:0] m_lo, m_hi;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_counter #(.WIDTH(4)) u_dut (
      .clk(clk), .clr_async_n(ac), .ld_async_n(al), .clr_sync_n(sc), .ld_sync_n(sl),
      .en_local(p), .en_chain(t), .par_d(d[3:0]), .out_en_n(oe),
      .cnt_q(q_lo), .carry_ripple(rip_lo), .carry_clocked(cc_lo)
   );

   // R9: the upper stage's chain enable is the lower stage's ripple carry.
   prog_counter #(.WIDTH(4)) u_dut_hi (
      .clk(clk), .clr_async_n(ac), .ld_async_n(al), .clr_sync_n(sc), .ld_sync_n(sl),
      .en_local(p), .en_chain(rip_lo), .par_d(d[7:4]), .out_en_n(oe),
      .cnt_q(q_hi), .carry_ripple(rip_hi), .carry_clocked(cc_hi)
   );

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic exp_rip_lo();
      return t && (m_lo == 4'hF);
   endfunction

   function automatic logic exp_rip_hi();
      return exp_rip_lo() && (m_hi == 4'hF);
   endfunction

   task automatic model_async();
      if (!ac) begin
         m_lo = 4'h0; m_hi = 4'h0;
      end else if (!al) begin
         m_lo = d[3:0]; m_hi = d[7:4];
      end
   endtask

   task automatic model_sync();
      logic r;
      r = exp_rip_lo();
      if (ac && al) begin
         if (!sc) begin
            m_lo = 4'h0; m_hi = 4'h0;
         end else if (!sl) begin
            m_lo = d[3:0]; m_hi = d[7:4];
         end else begin
            if (p && r) m_hi = m_hi + 4'h1;
            if (p && t) m_lo = m_lo + 4'h1;
         end
      end
   endtask

   task automatic check_outs(input string tag, input bit low_phase);
      chk(tag, q_lo, oe ? 4'bzzzz : m_lo);
      chk(tag, q_hi, oe ? 4'bzzzz : m_hi);
      chk("R6", {3'b0, rip_lo}, {3'b0, exp_rip_lo()});
      chk("R6", {3'b0, rip_hi}, {3'b0, exp_rip_hi()});
      if (low_phase) begin
         chk("R7", {3'b0, cc_lo}, {3'b0, exp_rip_lo() && p});
         chk("R7", {3'b0, cc_hi}, {3'b0, exp_rip_hi() && p});
      end else begin
         chk("R7", {3'b0, cc_lo}, 4'h0);
         chk("R7", {3'b0, cc_hi}, 4'h0);
      end
   endtask

   // Called one time unit after a rising edge.
   task automatic cyc(input string tag, input logic i_ac, i_al, i_sc, i_sl,
                      input logic i_p, i_t, i_oe, input logic [7:0] i_d);
      ac = i_ac; al = i_al; sc = i_sc; sl = i_sl; p = i_p; t = i_t; oe = i_oe; d = i_d;
      #1;
      model_async();
      check_outs(tag, 1'b0);
      #7;
      check_outs(tag, 1'b1);
      @(posedge clk);
      model_sync();
      model_async();
      #1;
   endtask

   initial begin
      ac = 1'b0; al = 1'b0; sc = 1'b0; sl = 1'b0; p = 1'b1; t = 1'b1; oe = 1'b0; d = 8'hA5;
      m_lo = 4'h0; m_hi = 4'h0;
      @(posedge clk); #1;
      // R1: reset state; the immediate clear beats the immediate load and both edge actions.
      cyc("R1", 0, 0, 0, 0, 1, 1, 0, 8'hA5);
      cyc("R1", 0, 0, 0, 0, 1, 1, 0, 8'h5A);
      // R2: the immediate load follows the data and beats the edge clear and load.
      cyc("R2", 1, 0, 1, 1, 1, 1, 0, 8'h3C);
      cyc("R2", 1, 0, 0, 0, 1, 1, 0, 8'hC7);
      // R5 / R9: count through a lower-stage wrap.
      for (int i = 0; i < 12; i++) cyc("R9", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R4: the edge load beats counting.
      cyc("R4", 1, 1, 1, 0, 1, 1, 0, 8'h2E);
      for (int i = 0; i < 3; i++) cyc("R5", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R3: the edge clear beats the edge load and counting.
      cyc("R3", 1, 1, 0, 0, 1, 1, 0, 8'h99);
      cyc("R3", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R4 with both enables low.
      cyc("R4", 1, 1, 1, 0, 0, 0, 0, 8'hFD);
      // R5: hold with either enable low.
      cyc("R5", 1, 1, 1, 1, 0, 1, 0, 8'h00);
      cyc("R5", 1, 1, 1, 1, 0, 1, 0, 8'h00);
      cyc("R5", 1, 1, 1, 1, 1, 0, 0, 8'h00);
      cyc("R5", 1, 1, 1, 1, 1, 0, 0, 8'h00);
      cyc("R5", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      cyc("R5", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R6 / R7: at all ones with the local enable low, the ripple carry is high and the clocked carry is low.
      cyc("R6", 1, 1, 1, 1, 0, 1, 0, 8'h00);
      cyc("R6", 1, 1, 1, 1, 1, 0, 0, 8'h00);
      // R9: the full 8-bit wrap, with both clocked carries in the low phase.
      cyc("R9", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      cyc("R9", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R8: high impedance while counting continues.
      for (int i = 0; i < 5; i++) cyc("R8", 1, 1, 1, 1, 1, 1, 1, 8'h00);
      cyc("R8", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      // R1 in mid-run, together with the immediate load.
      cyc("R1", 0, 0, 1, 1, 1, 1, 0, 8'h77);
      cyc("R2", 1, 0, 1, 1, 1, 1, 0, 8'h5A);
      cyc("R2", 1, 0, 1, 1, 1, 1, 0, 8'hF0);
      for (int i = 0; i < 20; i++) cyc("R9", 1, 1, 1, 1, 1, 1, 0, 8'h00);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule